// File: doc/BRIEF.md
# Time Slot Interchange Switching Core

This core reorders bytes between eight TDM input streams and eight TDM output streams. A frame holds 32 channels per stream, so 256 source positions can reach 256 destination positions. Serial-to-parallel conversion happens outside the core. In every clock cycle the core takes one byte per input stream for the current channel and delivers one byte per output stream. A frame pulse marks channel 0.

An external connection store is indexed by the channel that the core will emit next, and it returns one entry per output stream. Each entry names the input stream and the input channel to copy. In constant mode three rotating frame buffers hold the data, so every output frame carries a coherent copy of one whole input frame taken two frames earlier. In variable mode a single buffer is read as soon as the write pipeline allows, which gives the shortest latency.

Top module: `tsi_switch_core`

## Requirements
- R1: While rst_ni is low, out_data_o and out_chan_o are all zero.
- R2: A cycle with frame_i high is channel 0. Every cycle without frame_i is the previous channel plus one, wrapping from 31 to 0. conn_chan_o always shows the channel after the current one, so it reads 1 in a frame_i cycle.
- R3: In every cycle, out_chan_o equals the current channel, and out_data_o carries the bytes for that output channel.
- R4: Output stream o takes its entry from conn_src_i[8*o+7 : 8*o], which is looked up for channel conn_chan_o. Bits [7:5] of the entry select the input stream and bits [4:0] select the input channel.
- R5: With mode_i high (constant mode), a byte that enters on input channel n of frame N leaves on output channel m of frame N+2, for any n and m.
- R6: In constant mode, 64 + m - n cycles separate the input cycle from the output cycle. Between the end of the input slot and the start of the output slot this leaves 32 slots at the shortest (n=31, m=0) and 94 slots at the longest (n=0, m=31).
- R7: With mode_i low (variable mode) and m at least n+3, the byte leaves m - n cycles after it enters, in the same frame.
- R8: In variable mode with m equal to n, n+1 or n+2, the byte leaves m - n + 32 cycles after it enters.
- R9: In variable mode with m below n, the cycle distance is (m - n) mod 32. When that distance is below 3, it is increased by 32.
- R10: One input position can feed several output streams in the same frame, and each copy obeys the delay rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock, one channel per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1 = constant delay, 0 = variable delay; held static between resets |
| frame_i | input | 1 | High in the cycle that carries channel 0 |
| in_data_i | input | 64 | Current-channel byte of each input stream, stream s at [8s+7:8s] |
| conn_chan_o | output | 5 | Channel whose connection entries must be presented on conn_src_i |
| conn_src_i | input | 64 | Connection entries for conn_chan_o, one per output stream |
| out_data_o | output | 64 | Current-channel byte of each output stream |
| out_chan_o | output | 5 | Channel number carried by out_data_o |

## Verification
The assertions check on every cycle that the channel sequence follows the frame pulse, that out_chan_o trails conn_chan_o by one cycle, and that in constant mode the read buffer never matches either buffer being written. They also check the three-cycle shortest path of variable mode on output stream 0. Frame-level behaviour can only be shown by the bench's scenarios, because they follow each byte through whole frames: the N+2 placement, the 32 and 94 slot extremes, the wrap across frame boundaries and broadcast of one source to several outputs.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int unsigned NUM_BUF = 3;

  typedef logic [1:0] buf_idx_t;

  typedef enum logic {
    MODE_VAR   = 1'b0,
    MODE_CONST = 1'b1
  } delay_mode_e;

  function automatic buf_idx_t buf_inc(input buf_idx_t b);
    return (b == buf_idx_t'(NUM_BUF - 1)) ? buf_idx_t'(0) : b + buf_idx_t'(1);
  endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
  import tsi_pkg::*;
#(
  parameter int unsigned N_CH = 32,
  parameter int unsigned CW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          const_i,
  output logic [CW-1:0] cur_ch_o,
  output logic [CW-1:0] nxt_ch_o,
  output buf_idx_t      wr_buf_o,
  output buf_idx_t      rd_buf_o
);

  logic [CW-1:0] ch_q;
  buf_idx_t      wb_q, wb_cur, rd_sel;
  logic          last_ch;

  assign cur_ch_o = frame_i ? '0 : ch_q;
  assign last_ch  = (cur_ch_o == CW'(N_CH - 1));
  assign nxt_ch_o = last_ch ? '0 : cur_ch_o + CW'(1);

  // frame pulse opens a new write buffer
  assign wb_cur = frame_i ? buf_inc(wb_q) : wb_q;
  // prefetch of channel 0 already belongs to the next frame
  assign rd_sel = last_ch ? buf_inc(buf_inc(wb_cur)) : buf_inc(wb_cur);

  assign wr_buf_o = const_i ? wb_cur : buf_idx_t'(0);
  assign rd_buf_o = const_i ? rd_sel : buf_idx_t'(0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q <= '0;
      wb_q <= '0;
    end else begin
      ch_q <= nxt_ch_o;
      wb_q <= wb_cur;
    end
  end

endmodule

// File: rtl/tsi_data_bank.sv
module tsi_data_bank
  import tsi_pkg::*;
#(
  parameter int unsigned N_RD = 8,
  parameter int unsigned N_CH = 32,
  parameter int unsigned CW   = 5,
  parameter int unsigned DW   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    in_byte_i,
  input  logic             wr_en_i,
  input  buf_idx_t         wr_buf_i,
  input  logic [CW-1:0]    wr_ch_i,
  input  buf_idx_t         rd_buf_i,
  input  logic [N_RD*CW-1:0] rd_ch_i,
  output logic [N_RD*DW-1:0] rd_data_o
);

  logic [DW-1:0] byte_q;
  logic [DW-1:0] mem [NUM_BUF][N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byte_q <= '0;
    else         byte_q <= in_byte_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_buf_i][wr_ch_i] <= byte_q;
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_data_o[p*DW +: DW] = mem[rd_buf_i][rd_ch_i[p*CW +: CW]];
  end

endmodule

// File: rtl/tsi_out_select.sv
module tsi_out_select #(
  parameter int unsigned N_STR = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned SW    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SW-1:0]     sel_i,
  input  logic [N_STR*DW-1:0] cand_i,
  output logic [DW-1:0]     data_o
);

  logic [DW-1:0] pick;

  assign pick = cand_i[sel_i*DW +: DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= pick;
  end

endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
  import tsi_pkg::*;
#(
  parameter int unsigned N_STR = 8,
  parameter int unsigned N_CH  = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned SW   = (N_STR > 1) ? $clog2(N_STR) : 1,
  localparam int unsigned CW   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned EW   = SW + CW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic                 frame_i,
  input  logic [N_STR*DW-1:0]  in_data_i,
  output logic [CW-1:0]        conn_chan_o,
  input  logic [N_STR*EW-1:0]  conn_src_i,
  output logic [N_STR*DW-1:0]  out_data_o,
  output logic [CW-1:0]        out_chan_o
);

  delay_mode_e mode;
  logic        const_mode;
  logic [CW-1:0] cur_ch, nxt_ch;
  buf_idx_t    cur_wbuf, rd_buf;

  logic [CW-1:0] wr_ch_q;
  buf_idx_t    wr_buf_q;
  logic        wr_en_q;
  logic [CW-1:0] chan_q;

  logic [N_STR*CW-1:0]       rd_ch;
  logic [N_STR*N_STR*DW-1:0] bank_rd;
  logic [N_STR*DW-1:0]       cand [N_STR];

  assign mode       = delay_mode_e'(mode_i);
  assign const_mode = (mode == MODE_CONST);

  tsi_slot_timer #(.N_CH(N_CH), .CW(CW)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_i),
    .const_i  (const_mode),
    .cur_ch_o (cur_ch),
    .nxt_ch_o (nxt_ch),
    .wr_buf_o (cur_wbuf),
    .rd_buf_o (rd_buf)
  );

  assign conn_chan_o = nxt_ch;

  // write address staged alongside the byte register in each bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ch_q  <= '0;
      wr_buf_q <= '0;
      wr_en_q  <= 1'b0;
      chan_q   <= '0;
    end else begin
      wr_ch_q  <= cur_ch;
      wr_buf_q <= cur_wbuf;
      wr_en_q  <= 1'b1;
      chan_q   <= nxt_ch;
    end
  end

  assign out_chan_o = chan_q;

  for (genvar o = 0; o < N_STR; o++) begin : g_rdaddr
    assign rd_ch[o*CW +: CW] = conn_src_i[o*EW +: CW];
  end

  for (genvar s = 0; s < N_STR; s++) begin : g_bank
    tsi_data_bank #(.N_RD(N_STR), .N_CH(N_CH), .CW(CW), .DW(DW)) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_byte_i (in_data_i[s*DW +: DW]),
      .wr_en_i   (wr_en_q),
      .wr_buf_i  (wr_buf_q),
      .wr_ch_i   (wr_ch_q),
      .rd_buf_i  (rd_buf),
      .rd_ch_i   (rd_ch),
      .rd_data_o (bank_rd[s*N_STR*DW +: N_STR*DW])
    );
  end

  for (genvar o = 0; o < N_STR; o++) begin : g_out
    for (genvar s = 0; s < N_STR; s++) begin : g_cand
      assign cand[o][s*DW +: DW] = bank_rd[(s*N_STR + o)*DW +: DW];
    end

    tsi_out_select #(.N_STR(N_STR), .DW(DW), .SW(SW)) i_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (conn_src_i[o*EW + CW +: SW]),
      .cand_i (cand[o]),
      .data_o (out_data_o[o*DW +: DW])
    );
  end

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
#(
  parameter int unsigned N_STR = 8,
  parameter int unsigned N_CH  = 32,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = 5,
  parameter int unsigned SW    = 3,
  parameter int unsigned EW    = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                mode_i,
  input logic                frame_i,
  input logic [N_STR*DW-1:0] in_data_i,
  input logic [CW-1:0]       conn_chan_o,
  input logic [EW-1:0]       conn_src0_i,
  input logic [DW-1:0]       out0_i,
  input logic [CW-1:0]       out_chan_o,
  input buf_idx_t            cur_wbuf_i,
  input buf_idx_t            rd_buf_i,
  input buf_idx_t            wr_buf_q_i
);

  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assert_chan_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |-> conn_chan_o == CW'(1));

  assert_chan_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && !frame_i) |->
      conn_chan_o == (($past(conn_chan_o) == CW'(N_CH - 1)) ? CW'(0) : $past(conn_chan_o) + CW'(1)));

  assert_out_chan_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0) |-> out_chan_o == $past(conn_chan_o));

  assert_buf_apart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && mode_i && $past(mode_i)) |->
      (rd_buf_i != cur_wbuf_i && rd_buf_i != wr_buf_q_i));

  for (genvar s = 0; s < N_STR; s++) begin : g_fwd
    assert_short_path_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2 && !mode_i &&
       conn_src0_i == {SW'(s), CW'(conn_chan_o - CW'(3))}) |=>
        out0_i == $past(in_data_i[s*DW +: DW], 3));
  end

endmodule

bind tsi_switch_core tsi_switch_chk #(
  .N_STR(N_STR), .N_CH(N_CH), .DW(DW), .CW(CW), .SW(SW), .EW(EW)
) i_tsi_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .frame_i     (frame_i),
  .in_data_i   (in_data_i),
  .conn_chan_o (conn_chan_o),
  .conn_src0_i (conn_src_i[EW-1:0]),
  .out0_i      (out_data_o[DW-1:0]),
  .out_chan_o  (out_chan_o),
  .cur_wbuf_i  (cur_wbuf),
  .rd_buf_i    (rd_buf),
  .wr_buf_q_i  (wr_buf_q)
);

// File: tb/test_tsi_switch_core.sv
module test_tsi_switch_core;

  localparam int N_STR   = 8;
  localparam int N_CH    = 32;
  localparam int RUN_FR  = 40;
  localparam int RUN_CYC = RUN_FR * N_CH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        frame = 1'b0;
  logic [63:0] in_data = '0;
  logic [4:0]  conn_chan;
  logic [63:0] conn_src;
  logic [63:0] out_data;
  logic [4:0]  out_chan;

  logic [7:0] conn_tab [N_STR][N_CH];
  logic [7:0] hist [RUN_CYC][N_STR];

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int o = 0; o < N_STR; o++) conn_src[o*8 +: 8] = conn_tab[o][conn_chan];
  end

  tsi_switch_core i_tsi_switch_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .frame_i     (frame),
    .in_data_i   (in_data),
    .conn_chan_o (conn_chan),
    .conn_src_i  (conn_src),
    .out_data_o  (out_data),
    .out_chan_o  (out_chan)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int var_dist(input int n, input int m);
    int d = (m - n + N_CH) % N_CH;
    if (d < 3) d += N_CH;
    return d;
  endfunction

  function automatic string var_tag(input int n, input int m);
    if (m >= n + 3) return "R7";
    if (m >= n)     return "R8";
    return "R9";
  endfunction

  task automatic fill_table(input bit directed);
    for (int m = 0; m < N_CH; m++) begin
      for (int o = 0; o < N_STR; o++) begin
        int s = $urandom_range(0, N_STR - 1);
        int n = $urandom_range(0, N_CH - 1);
        if (directed) begin
          case (o)
            0: begin s = m % N_STR; n = N_CH - 1 - m; end
            1: n = m;
            2: n = (m + 31) % N_CH;
            3: n = (m + 30) % N_CH;
            4: n = (m + 29) % N_CH;
            5: n = (m + 1) % N_CH;
            6: n = (m + 2) % N_CH;
            default: begin s = conn_tab[1][m][7:5]; n = conn_tab[1][m][4:0]; end
          endcase
        end
        conn_tab[o][m] = {3'(s), 5'(n)};
      end
    end
  endtask

  task automatic run(input bit cmode, input bit directed);
    fill_table(directed);
    mode  = cmode;
    frame = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_data == 64'h0, "R1 out_data in reset", out_data, 0);
    chk(out_chan == 5'd0, "R1 out_chan in reset", out_chan, 0);
    rst_n = 1'b1;
    for (int k = 0; k < RUN_CYC; k++) begin
      if (k >= 1) begin
        int m = k % N_CH;
        int f = k / N_CH;
        chk(out_chan == 5'(m), "R3 out_chan", out_chan, m);
        for (int o = 0; o < N_STR; o++) begin
          int s = conn_tab[o][m][7:5];
          int n = conn_tab[o][m][4:0];
          int sc = -1;
          string tag;
          if (cmode) begin
            if (f >= 2) sc = (f - 2) * N_CH + n;
            tag = ((n == 31 && m == 0) || (n == 0 && m == 31)) ? "R6" : "R5";
          end else begin
            sc = k - var_dist(n, m);
            tag = var_tag(n, m);
          end
          if (!directed) tag = "R4";
          else if (o == 7) tag = "R10";
          if (sc >= 0)
            chk(out_data[o*8 +: 8] == hist[sc][s],
                $sformatf("%s mode=%0d out=%0d ch=%0d src=%0d/%0d", tag, cmode, o, m, s, n),
                out_data[o*8 +: 8], hist[sc][s]);
        end
      end
      in_data = {$urandom, $urandom};
      frame   = (k % N_CH == 0);
      for (int s = 0; s < N_STR; s++) hist[k][s] = in_data[s*8 +: 8];
      #1;
      chk(conn_chan == 5'((k + 1) % N_CH), "R2 conn_chan", conn_chan, (k + 1) % N_CH);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd7331));
    for (int o = 0; o < N_STR; o++)
      for (int m = 0; m < N_CH; m++) conn_tab[o][m] = '0;
    run(1'b1, 1'b1);
    run(1'b0, 1'b1);
    run(1'b1, 1'b0);
    run(1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule